// File: doc/BRIEF.md
# Command response buffer controller

This block is the device side of a memory-mapped command/response exchange with a security coprocessor. Host software reaches it over a simple word-wide register bus. The low window holds a packed control area of 32-bit registers. Two further windows hold the command bytes and the response bytes. The host follows a fixed sequence:

1. Make the device ready.
2. Fill the command buffer.
3. Set the start bit.
4. Poll start until the device clears it.
5. Check the error flag and read the response.

A parameterised stub stands in for the real command engine. The stub waits a fixed latency, then writes a 10-byte response. That response echoes the command's two tag bytes and reports the command length.

The control area also carries the following functions:
- A cancel flag, which aborts a running command with a fixed short response.
- Idle and ready request bits, which the device clears itself once each transition is done.
- An interrupt flag that marks completion.

The bus has three windows, selected by the top two address bits:
- `00`: the control area.
- `01`: the command buffer, starting at 0x400 with default parameters.
- `10`: the response buffer, starting at 0x800 with default parameters.

Buffer byte n sits in word n/4, lane n%4, little-endian within the word. Reads are combinational on the address.

Top module: `crb_ctrl`

## Requirements
- R1: Control area byte offsets are as follows:
  - request 0x00, status 0x04, cancel 0x08, start 0x0C;
  - interrupt enable 0x10, interrupt status 0x14;
  - command size 0x18, command address 0x1C (low) and 0x20 (high);
  - response size 0x24, response address 0x28 (low) and 0x2C (high).
  The sizes read as the buffer byte counts (64), the low address words read as the window bases (0x400 and 0x800), and the high words read 0. After reset the status register reads 0x2 (bit 1 is idle, bit 0 is error) and all other writable registers read 0.
- R2: Writing 1 to request bit 1 makes the device ready, so status bit 1 reads 0. Writing 1 to request bit 0 makes it idle, so status bit 1 reads 1. Each request bit reads 1 until its transition finishes, then reads 0. When both bits are written together, the go-idle request wins.
- R3: A write of 1 to start bit 0 is ignored while the device is idle or while start already reads 1. An accepted start reads 1 while busy and falls to 0 within LATENCY+2 cycles.
- R4: A normal response is 10 bytes long:
  - bytes 0–1 copy command bytes 0–1;
  - bytes 2–5 hold the big-endian total length, which is 10;
  - bytes 6–9 hold the command's own big-endian length, taken from command bytes 2–5.
- R5: A command whose big-endian length in bytes 2–5 exceeds the command size is not executed. Start falls, status bit 0 sets, and the response buffer is left untouched.
- R6: Status bit 0 clears when the next start is accepted.
- R7: Cancel bit 0 set while busy makes start fall within 2 cycles. The response then reads bytes 80 01, length 10, and code 00 00 01 01 in bytes 6–9, and status bit 0 stays 0. The cancel bit keeps reading 1 until the host writes 0.
- R8: Command buffer writes are dropped while start reads 1.
- R9: When interrupt enable bit 0 is 1, completion sets interrupt status bit 0. Writing 1 to that bit clears it. If a clear and a set land in the same cycle, the set wins.
- R10: A go-idle request made while busy completes only after the command has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | ADDR_W | Byte address; the top two bits pick the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The interrupt flag can receive the device's completion set and the host's write-one-to-clear in the same clock edge. The bench provokes this by timing the clearing write to land exactly on the edge where start falls, which is LATENCY+1 edges after the start write. It then judges that the flag still reads 1. A later clearing write with no completion must bring the flag to 0.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int RSP_LEN  = 10;
  localparam int HEAD_CMD = 6;

  localparam logic [5:0] OFS_REQ    = 6'h00;
  localparam logic [5:0] OFS_STS    = 6'h04;
  localparam logic [5:0] OFS_CANCEL = 6'h08;
  localparam logic [5:0] OFS_START  = 6'h0C;
  localparam logic [5:0] OFS_INTEN  = 6'h10;
  localparam logic [5:0] OFS_INTSTS = 6'h14;
  localparam logic [5:0] OFS_CSIZE  = 6'h18;
  localparam logic [5:0] OFS_CADDRL = 6'h1C;
  localparam logic [5:0] OFS_CADDRH = 6'h20;
  localparam logic [5:0] OFS_RSIZE  = 6'h24;
  localparam logic [5:0] OFS_RADDRL = 6'h28;
  localparam logic [5:0] OFS_RADDRH = 6'h2C;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/crb_bytebuf.sv
module crb_bytebuf #(
  parameter int DEPTH = 64,
  parameter int HEAD  = 10
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH/4)-1:0] wr_idx,
  input  logic [31:0]              wr_data,
  input  logic                     ld_en,
  input  logic [HEAD*8-1:0]        ld_data,
  input  logic [$clog2(DEPTH/4)-1:0] rd_idx,
  output logic [31:0]              rd_data,
  output logic [HEAD*8-1:0]        head
);
  localparam int IW = $clog2(DEPTH/4);
  localparam int AW = IW + 2;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) mem[{wr_idx, 2'(k)}] <= wr_data[8*k +: 8];
    end else if (ld_en) begin
      for (int k = 0; k < HEAD; k++) mem[AW'(k)] <= ld_data[8*k +: 8];
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_rd
    assign rd_data[8*k +: 8] = mem[{rd_idx, 2'(k)}];
  end

  for (genvar k = 0; k < HEAD; k++) begin : g_head
    assign head[8*k +: 8] = mem[AW'(k)];
  end
endmodule

// File: rtl/crb_seq.sv
module crb_seq
  import crb_pkg::*;
#(
  parameter int LATENCY   = 4,
  parameter int TRANS_CYC = 3,
  parameter int CMD_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_wr,
  input  logic [1:0]            req_wr,
  input  logic                  cancel,
  input  logic [HEAD_CMD*8-1:0] cmd_head,
  output logic                  start_o,
  output logic                  idle_o,
  output logic                  err_o,
  output logic [1:0]            req_o,
  output logic                  rsp_ld,
  output logic [RSP_LEN*8-1:0]  rsp_data,
  output logic                  done
);
  localparam int LW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam int TW = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;

  seq_st_t st_q, st_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [TW-1:0] tcnt_q, tcnt_n;
  logic start_q, start_n, idle_q, idle_n, err_q, err_n;
  logic [1:0] req_q, req_n;
  logic accept;
  logic [31:0] cmd_len;
  logic oversize;
  logic [RSP_LEN*8-1:0] rsp_norm, rsp_cncl;

  assign cmd_len  = {cmd_head[23:16], cmd_head[31:24], cmd_head[39:32], cmd_head[47:40]};
  assign oversize = cmd_len > 32'(CMD_BYTES);
  assign rsp_norm = {cmd_len[7:0], cmd_len[15:8], cmd_len[23:16], cmd_len[31:24],
                     8'd10, 8'd0, 8'd0, 8'd0, cmd_head[15:8], cmd_head[7:0]};
  assign rsp_cncl = {8'h01, 8'h01, 8'h00, 8'h00, 8'd10, 24'd0, 8'h01, 8'h80};
  assign rsp_data = cancel ? rsp_cncl : rsp_norm;
  assign accept   = start_wr && !start_q && !idle_q;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    tcnt_n  = tcnt_q;
    start_n = start_q;
    idle_n  = idle_q;
    err_n   = err_q;
    req_n   = req_q | req_wr;
    rsp_ld  = 1'b0;
    done    = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (accept) begin
          start_n = 1'b1;
          err_n   = 1'b0;
          st_n    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cancel) begin
          rsp_ld = 1'b1; done = 1'b1; start_n = 1'b0; st_n = ST_WAIT;
        end else if (oversize) begin
          err_n = 1'b1; done = 1'b1; start_n = 1'b0; st_n = ST_WAIT;
        end else begin
          cnt_n = LW'(LATENCY - 1);
          st_n  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cancel || cnt_q == '0) begin
          rsp_ld = 1'b1; done = 1'b1; start_n = 1'b0; st_n = ST_WAIT;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = ST_WAIT;
    endcase
    // idle/ready transitions run only while no command is in flight
    if (st_q == ST_WAIT && !accept && req_q != 2'b00) begin
      if (tcnt_q == TW'(TRANS_CYC - 1)) begin
        idle_n = req_q[0];
        req_n  = req_wr;
        tcnt_n = '0;
      end else begin
        tcnt_n = tcnt_q + 1'b1;
      end
    end else if (req_q == 2'b00) begin
      tcnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      start_q <= 1'b0;
      idle_q  <= 1'b1;
      err_q   <= 1'b0;
      req_q   <= 2'b00;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      tcnt_q  <= tcnt_n;
      start_q <= start_n;
      idle_q  <= idle_n;
      err_q   <= err_n;
      req_q   <= req_n;
    end
  end

  assign start_o = start_q;
  assign idle_o  = idle_q;
  assign err_o   = err_q;
  assign req_o   = req_q;
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CMD_BYTES = 64,
  parameter int RSP_BYTES = 64,
  parameter int LATENCY   = 4,
  parameter int TRANS_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int WIN_W    = ADDR_W - 2;
  localparam int CMD_BASE = 1 << WIN_W;
  localparam int RSP_BASE = 2 << WIN_W;
  localparam int CIW      = $clog2(CMD_BYTES / 4);
  localparam int RIW      = $clog2(RSP_BYTES / 4);

  logic rst_n_s;
  logic [1:0] win;
  logic [5:0] ofs;
  logic ctrl_hit, wr_ctrl, cmd_wr_req, cmd_wr;
  logic start_wr;
  logic [1:0] req_wr, req_q;
  logic cancel_q, cancel_n, int_en_q, int_en_n, int_q, int_n;
  logic start_q, idle_q, err_q, rsp_ld, done;
  logic [RSP_LEN*8-1:0] rsp_data, rsp_head;
  logic [HEAD_CMD*8-1:0] cmd_head;
  logic [31:0] cmd_rd, rsp_rd;

  crb_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign win        = bus_addr[ADDR_W-1 -: 2];
  assign ofs        = bus_addr[5:0];
  assign ctrl_hit   = (win == 2'b00) && (bus_addr[WIN_W-1:6] == '0);
  assign wr_ctrl    = bus_wr && ctrl_hit;
  assign cmd_wr_req = bus_wr && (win == 2'b01);
  assign cmd_wr     = cmd_wr_req && !start_q;
  assign start_wr   = wr_ctrl && (ofs == OFS_START) && bus_wdata[0];
  assign req_wr     = (wr_ctrl && ofs == OFS_REQ) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    cancel_n = (wr_ctrl && ofs == OFS_CANCEL) ? bus_wdata[0] : cancel_q;
    int_en_n = (wr_ctrl && ofs == OFS_INTEN)  ? bus_wdata[0] : int_en_q;
    // a completion set outranks a same-cycle clear
    int_n    = (done && int_en_q) ||
               (int_q && !(wr_ctrl && ofs == OFS_INTSTS && bus_wdata[0]));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cancel_q <= 1'b0;
      int_en_q <= 1'b0;
      int_q    <= 1'b0;
    end else begin
      cancel_q <= cancel_n;
      int_en_q <= int_en_n;
      int_q    <= int_n;
    end
  end

  crb_seq #(.LATENCY(LATENCY), .TRANS_CYC(TRANS_CYC), .CMD_BYTES(CMD_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n_s), .start_wr(start_wr), .req_wr(req_wr),
    .cancel(cancel_q), .cmd_head(cmd_head), .start_o(start_q), .idle_o(idle_q),
    .err_o(err_q), .req_o(req_q), .rsp_ld(rsp_ld), .rsp_data(rsp_data), .done(done)
  );

  crb_bytebuf #(.DEPTH(CMD_BYTES), .HEAD(HEAD_CMD)) i_cmdbuf (
    .clk(clk), .wr_en(cmd_wr), .wr_idx(bus_addr[CIW+1:2]), .wr_data(bus_wdata),
    .ld_en(1'b0), .ld_data('0), .rd_idx(bus_addr[CIW+1:2]), .rd_data(cmd_rd),
    .head(cmd_head)
  );

  crb_bytebuf #(.DEPTH(RSP_BYTES), .HEAD(RSP_LEN)) i_rspbuf (
    .clk(clk), .wr_en(1'b0), .wr_idx('0), .wr_data(32'd0),
    .ld_en(rsp_ld), .ld_data(rsp_data), .rd_idx(bus_addr[RIW+1:2]), .rd_data(rsp_rd),
    .head(rsp_head)
  );

  always_comb begin
    bus_rdata = 32'd0;
    if (win == 2'b01) begin
      bus_rdata = cmd_rd;
    end else if (win == 2'b10) begin
      bus_rdata = rsp_rd;
    end else if (ctrl_hit) begin
      unique case (ofs)
        OFS_REQ:    bus_rdata = {30'd0, req_q};
        OFS_STS:    bus_rdata = {30'd0, idle_q, err_q};
        OFS_CANCEL: bus_rdata = {31'd0, cancel_q};
        OFS_START:  bus_rdata = {31'd0, start_q};
        OFS_INTEN:  bus_rdata = {31'd0, int_en_q};
        OFS_INTSTS: bus_rdata = {31'd0, int_q};
        OFS_CSIZE:  bus_rdata = 32'(CMD_BYTES);
        OFS_CADDRL: bus_rdata = 32'(CMD_BASE);
        OFS_RSIZE:  bus_rdata = 32'(RSP_BYTES);
        OFS_RADDRL: bus_rdata = 32'(RSP_BASE);
        default:    bus_rdata = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/crb_ctrl_chk.sv
module crb_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_q,
  input logic        idle_q,
  input logic        err_q,
  input logic        cancel_q,
  input logic        int_q,
  input logic        int_en_q,
  input logic        done,
  input logic        rsp_ld,
  input logic        cmd_wr_req,
  input logic [47:0] cmd_head
);
  AST_IDLE_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !start_q); // R3

  AST_CANCEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && cancel_q |=> !start_q); // R7

  AST_CANCEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && cancel_q |=> !err_q); // R7

  AST_RSP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ld |=> !err_q); // R5

  AST_INT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && int_en_q |=> int_q); // R9

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && cmd_wr_req |=> $stable(cmd_head)); // R8
endmodule

bind crb_ctrl crb_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n_s), .start_q(start_q), .idle_q(idle_q), .err_q(err_q),
  .cancel_q(cancel_q), .int_q(int_q), .int_en_q(int_en_q), .done(done),
  .rsp_ld(rsp_ld), .cmd_wr_req(cmd_wr_req), .cmd_head(cmd_head)
);

// File: tb/test_crb_ctrl.sv
module test_crb_ctrl;
  localparam int LAT = 4;
  localparam logic [11:0] A_REQ = 12'h000, A_STS = 12'h004, A_CAN = 12'h008,
                          A_START = 12'h00C, A_IEN = 12'h010, A_IST = 12'h014,
                          A_CMD = 12'h400, A_RSP = 12'h800;

  typedef struct packed { logic err; logic [79:0] rsp; } exp_t;

  logic clk, rst_n, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_chk = 0, n_fail = 0;
  exp_t sb[$];

  crb_ctrl #(.LATENCY(LAT)) i_crb_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(string r, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic load_cmd(logic [15:0] tag, logic [31:0] len);
    wr(A_CMD,     {len[23:16], len[31:24], tag[7:0], tag[15:8]});
    wr(A_CMD + 4, {16'd0, len[7:0], len[15:8]});
  endtask

  task automatic push_normal(logic [15:0] tag, logic [31:0] len);
    exp_t e;
    e.err = 1'b0;
    e.rsp = {len[7:0], len[15:8], len[23:16], len[31:24], 8'd10, 24'd0, tag[7:0], tag[15:8]};
    sb.push_back(e);
  endtask

  task automatic push_special(logic is_err);
    exp_t e;
    e.err = is_err;
    e.rsp = {8'h01, 8'h01, 16'd0, 8'd10, 24'd0, 8'h01, 8'h80};
    sb.push_back(e);
  endtask

  task automatic poll(logic [11:0] a, logic [31:0] mask, string r);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(a, d);
      if ((d & mask) == 0) return;
    end
    check(r, "poll timeout", d & mask, 32'd0);
  endtask

  // monitor: waits for completion and compares against the scoreboard head
  task automatic collect(string r);
    exp_t e;
    logic [31:0] d;
    poll(A_START, 32'h1, r);
    e = sb.pop_front();
    rd(A_STS, d);
    check(r, "error bit", {31'd0, d[0]}, {31'd0, e.err});
    if (!e.err) begin
      rd(A_RSP, d);     check(r, "rsp word0", d, e.rsp[31:0]);
      rd(A_RSP + 4, d); check(r, "rsp word1", d, e.rsp[63:32]);
      rd(A_RSP + 8, d); check(r, "rsp bytes8-9", {16'd0, d[15:0]}, {16'd0, e.rsp[79:64]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values and map
    rd(A_REQ, d);   check("R1", "request", d, 32'd0);
    rd(A_STS, d);   check("R1", "status", d, 32'd2);
    rd(A_CAN, d);   check("R1", "cancel", d, 32'd0);
    rd(A_START, d); check("R1", "start", d, 32'd0);
    rd(A_IEN, d);   check("R1", "int enable", d, 32'd0);
    rd(A_IST, d);   check("R1", "int status", d, 32'd0);
    rd(12'h018, d); check("R1", "cmd size", d, 32'd64);
    rd(12'h01C, d); check("R1", "cmd addr lo", d, 32'h400);
    rd(12'h020, d); check("R1", "cmd addr hi", d, 32'd0);
    rd(12'h024, d); check("R1", "rsp size", d, 32'd64);
    rd(12'h028, d); check("R1", "rsp addr lo", d, 32'h800);
    rd(12'h02C, d); check("R1", "rsp addr hi", d, 32'd0);

    // R3 start ignored while idle
    wr(A_START, 32'd1);
    rd(A_START, d); check("R3", "start while idle", d, 32'd0);

    // R2 become ready
    wr(A_REQ, 32'd2);
    rd(A_REQ, d); check("R2", "ready req pending", d, 32'd2);
    poll(A_REQ, 32'h3, "R2");
    rd(A_STS, d); check("R2", "ready status", d, 32'd0);

    // R4 normal command, R9 interrupt
    wr(A_IEN, 32'd1);
    load_cmd(16'h8001, 32'd10);
    wr(A_START, 32'd1);
    push_normal(16'h8001, 32'd10);
    rd(A_START, d); check("R3", "busy start reads 1", d, 32'd1);
    collect("R4");
    rd(A_IST, d); check("R9", "int set on completion", d, 32'd1);
    wr(A_IST, 32'd1);
    rd(A_IST, d); check("R9", "int w1c", d, 32'd0);

    // R8 command buffer locked while busy
    load_cmd(16'h1234, 32'd6);
    wr(A_START, 32'd1);
    push_normal(16'h1234, 32'd6);
    wr(A_CMD, 32'hDEADBEEF);
    collect("R8");
    rd(A_CMD, d); check("R8", "cmd word0 kept", d, 32'h06001234 >> 0 & 32'h0 | {8'h00, 8'h00, 8'h34, 8'h12});

    // R9 completion set and clear in the same cycle: set wins
    load_cmd(16'h4321, 32'd8);
    wr(A_START, 32'd1);
    push_normal(16'h4321, 32'd8);
    repeat (LAT - 1) @(negedge clk);
    wr(A_IST, 32'd1);
    collect("R9");
    rd(A_IST, d); check("R9", "set wins over clear", d, 32'd1);
    wr(A_IST, 32'd1);
    rd(A_IST, d); check("R9", "clear alone", d, 32'd0);

    // R5 oversized command, R6 error clears on next start
    load_cmd(16'h5555, 32'd65);
    wr(A_START, 32'd1);
    push_special(1'b1);
    collect("R5");
    rd(A_RSP, d); check("R5", "rsp untouched", d, {8'h00, 8'h00, 8'h21, 8'h43});
    load_cmd(16'h0102, 32'd64);
    wr(A_START, 32'd1);
    push_normal(16'h0102, 32'd64);
    collect("R6");

    // R7 cancel while busy
    load_cmd(16'h7777, 32'd12);
    wr(A_START, 32'd1);
    wr(A_CAN, 32'd1);
    rd(A_START, d); check("R7", "start falls within 2 cycles", d, 32'd0);
    push_special(1'b0);
    collect("R7");
    rd(A_CAN, d); check("R7", "cancel held", d, 32'd1);
    wr(A_CAN, 32'd0);
    rd(A_CAN, d); check("R7", "cancel withdrawn", d, 32'd0);

    // R2 both bits at once: go-idle wins
    wr(A_REQ, 32'd3);
    poll(A_REQ, 32'h3, "R2");
    rd(A_STS, d); check("R2", "both requests -> idle", d, 32'd2);
    wr(A_REQ, 32'd2);
    poll(A_REQ, 32'h3, "R2");

    // R10 go-idle while busy waits for completion
    load_cmd(16'hA5A5, 32'd20);
    wr(A_START, 32'd1);
    push_normal(16'hA5A5, 32'd20);
    wr(A_REQ, 32'd1);
    rd(A_STS, d); check("R10", "not idle while busy", d, 32'd0);
    rd(A_REQ, d); check("R10", "go-idle pending", d, 32'd1);
    collect("R10");
    poll(A_REQ, 32'h3, "R10");
    rd(A_STS, d); check("R10", "idle after command", d, 32'd2);
    wr(A_START, 32'd1);
    rd(A_START, d); check("R3", "start ignored when idle again", d, 32'd0);

    summary();
    $finish;
  end
endmodule